// File: doc/BRIEF.md
# Gated Timer/Counter with Prescaled Mode

This block is a single timer/counter channel of the kind found beside a small processor core. It holds a count split into a high byte and a low byte and increments it by one on each qualified count event. The count event is either an internal tick, produced once every six clocks by a free-running divider, or a falling edge on an external count pin, detected after a two-flop synchroniser. A mode input chooses the counter width. In the 13-bit mode the low five bits of the low byte act as a divide-by-32 prescaler feeding the high byte. In the 16-bit mode both bytes form one counter.

Counting is allowed only while the run input is high and either the gate enable is low or the gate pin is high. With the gate enable set, the count accumulates only while the gate pin is high, which lets software measure the width of a pulse on that pin. When the count wraps from all ones to zero, a sticky overflow flag is set. Software clears the flag with a clear strobe, or an interrupt controller clears it with an acknowledge strobe. Software loads either byte through a write port at any time.

The count-pin detector is a two-state machine with states PIN_LO and PIN_HI. The transition PIN_LO to PIN_HI (synchronised pin rises) gives no event. The transition PIN_HI to PIN_LO (synchronised pin falls) gives one count event. The self-loops on PIN_LO and PIN_HI (level held) give nothing.

Top module: `gated_tmr`

## Requirements
- R1: After reset the high byte, the low byte and the overflow flag all read 0.
- R2: With mode_sel = 1 the count is the 16-bit value {cnt_hi, cnt_lo}, and each count event adds one, carrying from the low byte into the high byte (0x00FF becomes 0x0100).
- R3: With mode_sel = 0 the count is the 13-bit value {cnt_hi, cnt_lo[4:0]}. Each event adds one, carrying from bit 4 of the low byte into bit 0 of the high byte. Counting leaves cnt_lo[7:5] unchanged.
- R4: A count event that wraps the active counter from all ones to zero (0x1FFF in mode 0, 0xFFFF in mode 1) sets ovf_flag in the same clock edge as the wrap.
- R5: While run_en = 0 no count event changes the count.
- R6: While run_en = 1 and gate_en = 1, events are counted only while gate_pin is high. With gate_en = 0, gate_pin has no effect.
- R7: With cnt_sel = 0 the event source is a tick that occurs once in every 6 clocks, from a divider that runs freely from reset, so 60 enabled clocks give exactly 10 increments.
- R8: With cnt_sel = 1 each 1-to-0 transition of cnt_pin gives exactly one increment, on the third rising clock edge after the pin falls. Rising edges and held levels give none.
- R9: Raising run_en does not change the count; counting resumes from the value already held.
- R10: ovf_flag stays set until flag_clr or int_ack is high at a clock edge. If an overflow occurs at the same edge as a clear, the flag stays set.
- R11: A write to either byte at the same edge as a count event takes effect, and that event is dropped. The byte that is not written keeps its value.
- R12: wr_hi loads wr_data into cnt_hi and wr_lo loads wr_data into cnt_lo at the next clock edge, whatever the state of run_en.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_hi | input | 1 | Load wr_data into the high byte |
| wr_lo | input | 1 | Load wr_data into the low byte |
| wr_data | input | 8 | Write data for the byte loads |
| run_en | input | 1 | Run control |
| gate_en | input | 1 | When 1, counting also needs gate_pin high |
| cnt_sel | input | 1 | Event source: 0 = divided clock tick, 1 = cnt_pin falling edge |
| mode_sel | input | 1 | Width: 0 = 13-bit prescaled, 1 = 16-bit |
| cnt_pin | input | 1 | External count pin (asynchronous) |
| gate_pin | input | 1 | External gate pin (synchronous to clk) |
| flag_clr | input | 1 | Software clear of the overflow flag |
| int_ack | input | 1 | Interrupt acknowledge, clears the overflow flag |
| cnt_hi | output | 8 | High byte of the count |
| cnt_lo | output | 8 | Low byte of the count |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A wrong divider phase or divider modulus shows within one 60-clock window as an increment total other than 10. A stuck or wrong edge-detector state shows on the next pulse on the count pin, as a missed or doubled count, or as a count that lands on the wrong edge. A bad carry in the 13-bit layout shows at the first prescaler rollover, as a high byte that does not step or upper low-byte bits that change. A missed or wrong flag update shows at the very edge where the count wraps, where the flag and a zero count must appear together.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic {SRC_TICK = 1'b0, SRC_PIN = 1'b1} src_e;
    typedef enum logic {MODE_13 = 1'b0, MODE_16 = 1'b1} width_e;
    typedef enum logic {PIN_LO = 1'b0, PIN_HI = 1'b1} pin_st_e;
endpackage

// File: rtl/tmr_tick_div.sv
module tmr_tick_div #(
    parameter int RATIO = 6
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (RATIO > 2) ? $clog2(RATIO) : 1;
    localparam logic [CW-1:0] LAST = CW'(RATIO - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (div_q == LAST)
            div_q <= '0;
        else
            div_q <= div_q + CW'(1);
    end

    assign tick_o = (div_q == LAST);
endmodule

// File: rtl/tmr_pin_edge.sv
module tmr_pin_edge import tmr_pkg::*; #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES-1:0] sync_q;
    logic              level;
    pin_st_e           st_q, st_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_q <= '0;
        else
            sync_q <= {sync_q[STAGES-2:0], pin_i};
    end

    assign level = sync_q[STAGES-1];

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= PIN_LO;
        else
            st_q <= st_d;
    end

    // next state and output
    always_comb begin
        st_d   = st_q;
        fall_o = 1'b0;
        unique case (st_q)
            PIN_LO: if (level) st_d = PIN_HI;
            PIN_HI: if (!level) begin
                st_d   = PIN_LO;
                fall_o = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core import tmr_pkg::*; #(
    parameter int BYTE_W  = 8,
    parameter int PRESC_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic              mode_i,
    input  logic              wr_hi_i,
    input  logic              wr_lo_i,
    input  logic [BYTE_W-1:0] wr_data_i,
    output logic [BYTE_W-1:0] hi_o,
    output logic [BYTE_W-1:0] lo_o,
    output logic              wrap_o
);
    localparam int FULL_W  = 2 * BYTE_W;
    localparam int SHORT_W = BYTE_W + PRESC_W;

    logic [BYTE_W-1:0]  hi_q, lo_q, hi_d, lo_d;
    logic [FULL_W-1:0]  full_inc;
    logic [SHORT_W-1:0] short_inc;
    logic               full_ones, short_ones;

    always_comb begin
        full_inc   = {hi_q, lo_q} + FULL_W'(1);
        short_inc  = {hi_q, lo_q[PRESC_W-1:0]} + SHORT_W'(1);
        full_ones  = &{hi_q, lo_q};
        short_ones = &{hi_q, lo_q[PRESC_W-1:0]};
        hi_d   = hi_q;
        lo_d   = lo_q;
        wrap_o = 1'b0;
        if (wr_hi_i || wr_lo_i) begin
            if (wr_hi_i) hi_d = wr_data_i;
            if (wr_lo_i) lo_d = wr_data_i;
        end else if (step_i) begin
            unique case (width_e'(mode_i))
                MODE_16: begin
                    {hi_d, lo_d} = full_inc;
                    wrap_o       = full_ones;
                end
                MODE_13: begin
                    hi_d   = short_inc[SHORT_W-1:PRESC_W];
                    lo_d   = {lo_q[BYTE_W-1:PRESC_W], short_inc[PRESC_W-1:0]};
                    wrap_o = short_ones;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_d;
            lo_q <= lo_d;
        end
    end

    assign hi_o = hi_q;
    assign lo_o = lo_q;
endmodule

// File: rtl/gated_tmr.sv
module gated_tmr import tmr_pkg::*; #(
    parameter int BYTE_W      = 8,
    parameter int PRESC_W     = 5,
    parameter int DIV_RATIO   = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              run_en,
    input  logic              gate_en,
    input  logic              cnt_sel,
    input  logic              mode_sel,
    input  logic              cnt_pin,
    input  logic              gate_pin,
    input  logic              flag_clr,
    input  logic              int_ack,
    output logic [BYTE_W-1:0] cnt_hi,
    output logic [BYTE_W-1:0] cnt_lo,
    output logic              ovf_flag
);
    logic tick, fall, src_evt, enable, step, wrap, flag_q;

    tmr_tick_div #(.RATIO(DIV_RATIO)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tmr_pin_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cnt_pin),
        .fall_o (fall)
    );

    // R5 R6: run AND (gate off OR gate pin high)
    assign enable  = run_en && (!gate_en || gate_pin);
    assign src_evt = (src_e'(cnt_sel) == SRC_PIN) ? fall : tick;
    assign step    = enable && src_evt;

    tmr_count_core #(.BYTE_W(BYTE_W), .PRESC_W(PRESC_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .mode_i    (mode_sel),
        .wr_hi_i   (wr_hi),
        .wr_lo_i   (wr_lo),
        .wr_data_i (wr_data),
        .hi_o      (cnt_hi),
        .lo_o      (cnt_lo),
        .wrap_o    (wrap)
    );

    // R10: overflow outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (wrap)
            flag_q <= 1'b1;
        else if (flag_clr || int_ack)
            flag_q <= 1'b0;
    end

    assign ovf_flag = flag_q;
endmodule

// File: rtl/gated_tmr_chk.sv
module gated_tmr_chk #(
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_hi,
    input logic              wr_lo,
    input logic [BYTE_W-1:0] wr_data,
    input logic              run_en,
    input logic              gate_en,
    input logic              mode_sel,
    input logic              gate_pin,
    input logic              flag_clr,
    input logic              int_ack,
    input logic [BYTE_W-1:0] cnt_hi,
    input logic [BYTE_W-1:0] cnt_lo,
    input logic              ovf_flag
);
    logic [2*BYTE_W-1:0] cnt16;
    assign cnt16 = {cnt_hi, cnt_lo};

    // R5
    run_off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !wr_hi && !wr_lo) |=> $stable(cnt16));

    // R6
    gate_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && gate_en && !gate_pin && !wr_hi && !wr_lo) |=> $stable(cnt16));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !wr_hi && !wr_lo) |=>
        ((cnt16 == $past(cnt16)) || (cnt16 == $past(cnt16) + (2*BYTE_W)'(1))));

    // R3
    upper_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_sel && !wr_lo) |=> $stable(cnt_lo[BYTE_W-1:5]));

    // R4
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (cnt_hi == '0 && cnt_lo[4:0] == '0));

    // R10
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr && !int_ack) |=> ovf_flag);

    // R10
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_clr || int_ack) && !run_en) |=> !ovf_flag);

    // R12
    hi_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hi |=> (cnt_hi == $past(wr_data)));
endmodule

bind gated_tmr gated_tmr_chk #(.BYTE_W(BYTE_W)) u_chk (.*);

// File: tb/gated_tmr_tb.sv
module gated_tmr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_hi = 1'b0, wr_lo = 1'b0;
    logic [7:0] wr_data = '0;
    logic       run_en = 1'b0, gate_en = 1'b0, cnt_sel = 1'b0, mode_sel = 1'b1;
    logic       cnt_pin = 1'b0, gate_pin = 1'b0, flag_clr = 1'b0, int_ack = 1'b0;
    logic [7:0] cnt_hi, cnt_lo;
    logic       ovf_flag;
    int         n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    gated_tmr u_dut (
        .clk(clk), .rst_n(rst_n), .wr_hi(wr_hi), .wr_lo(wr_lo), .wr_data(wr_data),
        .run_en(run_en), .gate_en(gate_en), .cnt_sel(cnt_sel), .mode_sel(mode_sel),
        .cnt_pin(cnt_pin), .gate_pin(gate_pin), .flag_clr(flag_clr), .int_ack(int_ack),
        .cnt_hi(cnt_hi), .cnt_lo(cnt_lo), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] hi, input logic [7:0] lo);
        @(negedge clk); wr_hi = 1'b1; wr_data = hi;
        @(negedge clk); wr_hi = 1'b0; wr_lo = 1'b1; wr_data = lo;
        @(negedge clk); wr_lo = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk); cnt_pin = 1'b1;
        repeat (3) @(negedge clk);
        cnt_pin = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // pin falls, then a control strobe is aligned with the counting edge
    task automatic pulse_with(input logic do_clr, input logic do_wr, input logic [7:0] d);
        @(negedge clk); cnt_pin = 1'b1;
        repeat (3) @(negedge clk);
        cnt_pin = 1'b0;
        @(posedge clk); @(posedge clk);
        @(negedge clk); flag_clr = do_clr; wr_lo = do_wr; wr_data = d;
        @(negedge clk); flag_clr = 1'b0; wr_lo = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1", "hi", cnt_hi, 0);
        chk("R1", "lo", cnt_lo, 0);
        chk("R1", "flag", ovf_flag, 0);
    endtask

    task automatic t_timer();
        cnt_sel = 1'b0; mode_sel = 1'b1; gate_en = 1'b0;
        load(8'h00, 8'h00);
        chk("R12", "load", {cnt_hi, cnt_lo}, 0);
        @(negedge clk); run_en = 1'b1;
        repeat (60) @(posedge clk);
        @(negedge clk); run_en = 1'b0;
        chk("R7", "60 clocks", {cnt_hi, cnt_lo}, 10);
        run_en = 1'b1;
        repeat (6) @(posedge clk);
        @(negedge clk); run_en = 1'b0;
        chk("R7", "6 clocks", {cnt_hi, cnt_lo}, 11);
        gate_en = 1'b1; gate_pin = 1'b0; run_en = 1'b1;
        repeat (60) @(posedge clk);
        @(negedge clk); run_en = 1'b0; gate_en = 1'b0;
        chk("R6", "gated timer", {cnt_hi, cnt_lo}, 11);
    endtask

    task automatic t_pin();
        cnt_sel = 1'b1; mode_sel = 1'b1;
        load(8'h00, 8'hFF);
        run_en = 1'b1;
        pulse();
        chk("R2", "carry", {cnt_hi, cnt_lo}, 16'h0100);
        @(negedge clk); cnt_pin = 1'b1;
        repeat (6) @(negedge clk);
        chk("R8", "rise and high level", {cnt_hi, cnt_lo}, 16'h0100);
        cnt_pin = 1'b0;
        @(posedge clk); @(posedge clk); #1;
        chk("R8", "before third edge", {cnt_hi, cnt_lo}, 16'h0100);
        @(posedge clk); #1;
        chk("R8", "at third edge", {cnt_hi, cnt_lo}, 16'h0101);
        repeat (6) @(negedge clk);
        chk("R8", "low level", {cnt_hi, cnt_lo}, 16'h0101);
        run_en = 1'b0;
        pulse();
        chk("R5", "run off", {cnt_hi, cnt_lo}, 16'h0101);
    endtask

    task automatic t_gate();
        cnt_sel = 1'b1; mode_sel = 1'b1; run_en = 1'b1;
        load(8'h00, 8'h20);
        gate_en = 1'b1; gate_pin = 1'b0;
        pulse();
        chk("R6", "gate low", {cnt_hi, cnt_lo}, 16'h0020);
        gate_pin = 1'b1;
        pulse();
        chk("R6", "gate high", {cnt_hi, cnt_lo}, 16'h0021);
        gate_en = 1'b0; gate_pin = 1'b0;
        pulse();
        chk("R6", "gate off", {cnt_hi, cnt_lo}, 16'h0022);
        run_en = 1'b0;
    endtask

    task automatic t_resume();
        cnt_sel = 1'b1; mode_sel = 1'b1; run_en = 1'b0;
        load(8'h12, 8'h34);
        @(negedge clk); run_en = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "run set", {cnt_hi, cnt_lo}, 16'h1234);
        pulse();
        chk("R9", "resume", {cnt_hi, cnt_lo}, 16'h1235);
        run_en = 1'b0;
    endtask

    task automatic t_mode0();
        cnt_sel = 1'b1; mode_sel = 1'b0; run_en = 1'b1;
        @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        load(8'h00, 8'hFE);
        pulse();
        chk("R3", "prescaler", {cnt_hi, cnt_lo}, 16'h00FF);
        chk("R4", "no wrap yet", ovf_flag, 0);
        pulse();
        chk("R3", "carry hi", cnt_hi, 8'h01);
        chk("R3", "low5", cnt_lo[4:0], 0);
        chk("R3", "upper3 kept", cnt_lo[7:5], 3'h7);
        load(8'hFF, 8'h1F);
        pulse();
        chk("R4", "wrap13 hi", cnt_hi, 0);
        chk("R4", "wrap13 low5", cnt_lo[4:0], 0);
        chk("R4", "wrap13 flag", ovf_flag, 1);
        run_en = 1'b0;
    endtask

    task automatic t_flag();
        cnt_sel = 1'b1; mode_sel = 1'b1; run_en = 1'b1;
        @(negedge clk); flag_clr = 1'b1; @(negedge clk); flag_clr = 1'b0;
        chk("R10", "clear", ovf_flag, 0);
        load(8'hFF, 8'hFF);
        pulse();
        chk("R4", "wrap16 count", {cnt_hi, cnt_lo}, 0);
        chk("R4", "wrap16 flag", ovf_flag, 1);
        repeat (5) @(negedge clk);
        chk("R10", "sticky", ovf_flag, 1);
        int_ack = 1'b1; @(negedge clk); int_ack = 1'b0;
        chk("R10", "ack", ovf_flag, 0);
        load(8'hFF, 8'hFF);
        pulse_with(1'b1, 1'b0, 8'h00);
        chk("R10", "overflow beats clear", ovf_flag, 1);
        chk("R4", "wrap with clear", {cnt_hi, cnt_lo}, 0);
        load(8'h00, 8'h10);
        pulse_with(1'b0, 1'b1, 8'h55);
        chk("R11", "write beats step", {cnt_hi, cnt_lo}, 16'h0055);
        run_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_timer();
        t_pin();
        t_gate();
        t_resume();
        t_mode0();
        t_flag();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule